// File: doc/BRIEF.md
# Configurable NMI Trigger Latch

This block turns one external non-maskable interrupt pin into a sticky, active-high request for an upstream interrupt controller. The pin is first brought into the local clock domain through a synchroniser. A programmable sense stage then detects one of four conditions on the pin: low level, high level, falling edge or rising edge. When the selected condition is seen, a set/reset latch is set. The latch output drives the upstream request directly, so the controller always sees a level-high request, whatever sense the pin uses.

Software talks to the block through a small word-addressed register port. One register selects the sense mode. Writing a one to bit 0 of the pending register clears the latch. Reading the pending register returns the latch state masked by an enable bit. The enable bit only masks the readable status. The upstream request itself is never gated.

Top module: `nmi_trigger_latch`

## Requirements
- R1: After reset, irqReq is 0, the sense register reads 0, the enable register reads 1 and the pending register reads 0. This holds while nmiPin is held high, because the synchroniser and previous-sample flops reset to 1.
- R2: The sense mode is held in bits [1:0] of the register at offset 0x0C, with 0 = low level, 1 = falling edge, 2 = high level and 3 = rising edge. Upper bits read as 0.
- R3: In rising-edge mode (3), a 0-to-1 pin transition sets the latch, and a 1-to-0 transition does not.
- R4: In falling-edge mode (1), a 1-to-0 pin transition sets the latch, and a 0-to-1 transition does not.
- R5: In high-level mode (2), a high pin sets the latch.
- R6: In low-level mode (0), a low pin sets the latch.
- R7: Once set, the latch and irqReq stay at 1 after the pin condition goes away, until software clears them.
- R8: A write to offset 0x10 with bit 0 = 1 clears the latch on that clock edge. A write there with bit 0 = 0 has no effect.
- R9: In a level mode, if the pin is still active when a clear is written, irqReq stays at 1.
- R10: If a set condition and a clear write fall on the same cycle, the set wins.
- R11: Bit 0 of the pending register at 0x10 reads as the latch ANDed with bit 0 of the enable register at offset 0x40. irqReq does not depend on the enable bit.
- R12: A pin change passes two synchroniser flops before detection. irqReq rises on the third rising clock edge after the change, and not before.
- R13: Reads from unmapped offsets return 0, and writes to unmapped offsets change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| nmiPin | input | 1 | Asynchronous external interrupt pin |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 8 | Register byte offset |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data (combinational from regAddr) |
| irqReq | output | 1 | Level-high request to the upstream controller |

## Verification
The bench builds the block with its defaults: a two-stage synchroniser, 8-bit offsets and 32-bit data. With these settings the exact three-edge latency from pin to request can be checked cycle by cycle. Directed sequences cover each sense mode and its opposite transition, clearing with the pin still active, and a clear landing on the same cycle as an edge event. A random phase mixes pin toggles with writes of every kind and compares the request and the masked pending bit against a cycle model on every cycle.

// File: rtl/nmi_latch_pkg.sv
package nmi_latch_pkg;

  typedef enum logic [1:0] {
    TRIG_LVL_LO    = 2'd0,
    TRIG_EDGE_FALL = 2'd1,
    TRIG_LVL_HI    = 2'd2,
    TRIG_EDGE_RISE = 2'd3
  } trig_e;

  // Strobes from the register control to the trigger datapath
  typedef struct packed {
    logic  clearPend;
    trig_e trigType;
  } ctl_strobe_t;

endpackage

// File: rtl/nmi_pin_sync.sv
module nmi_pin_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rstN,
  input  logic pinAsync,
  output logic pinSync
);

  logic [STAGES-1:0] chainQ;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rstN) chainQ[i] <= RESET_VAL;
          else       chainQ[i] <= pinAsync;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rstN) chainQ[i] <= RESET_VAL;
          else       chainQ[i] <= chainQ[i-1];
        end
      end
    end
  endgenerate

  assign pinSync = chainQ[STAGES-1];

endmodule

// File: rtl/nmi_trig_datapath.sv
module nmi_trig_datapath
  import nmi_latch_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        pinSync,
  input  ctl_strobe_t ctl,
  output logic        latchQ
);

  logic prevQ;
  logic setEvt;

  always_ff @(posedge clk) begin
    if (!rstN) prevQ <= 1'b1;
    else       prevQ <= pinSync;
  end

  always_comb begin
    unique case (ctl.trigType)
      TRIG_LVL_LO:    setEvt = ~pinSync;
      TRIG_EDGE_FALL: setEvt = prevQ & ~pinSync;
      TRIG_LVL_HI:    setEvt = pinSync;
      TRIG_EDGE_RISE: setEvt = ~prevQ & pinSync;
      default:        setEvt = 1'b0;
    endcase
  end

  // Set has priority over clear
  always_ff @(posedge clk) begin
    if (!rstN)              latchQ <= 1'b0;
    else if (setEvt)        latchQ <= 1'b1;
    else if (ctl.clearPend) latchQ <= 1'b0;
  end

  AST_RISE_SETS: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.trigType == TRIG_EDGE_RISE && $rose(pinSync)) |=> latchQ); // R3
  AST_FALL_SETS: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.trigType == TRIG_EDGE_FALL && $fell(pinSync)) |=> latchQ); // R4
  AST_HIGH_SETS: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.trigType == TRIG_LVL_HI && pinSync) |=> latchQ); // R5
  AST_LOW_SETS: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.trigType == TRIG_LVL_LO && !pinSync) |=> latchQ); // R6
  AST_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (latchQ && !ctl.clearPend) |=> latchQ); // R7
  AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.clearPend && ctl.trigType[0] && $stable(pinSync)) |=> !latchQ); // R8
  AST_LEVEL_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.clearPend && ctl.trigType == TRIG_LVL_HI && pinSync) |=> latchQ); // R9

endmodule

// File: rtl/nmi_reg_ctrl.sv
module nmi_reg_ctrl
  import nmi_latch_pkg::*;
#(
  parameter int                ADDR_W    = 8,
  parameter int                DATA_W    = 32,
  parameter logic [ADDR_W-1:0] TYPE_OFFS = 8'h0C,
  parameter logic [ADDR_W-1:0] PEND_OFFS = 8'h10,
  parameter logic [ADDR_W-1:0] EN_OFFS   = 8'h40,
  parameter logic              EN_RESET  = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  input  logic              latchQ,
  output ctl_strobe_t       ctl,
  output logic [DATA_W-1:0] regRdata
);

  localparam int PAD_TYPE = DATA_W - 2;
  localparam int PAD_BIT  = DATA_W - 1;

  trig_e trigQ;
  logic  enQ;
  logic  hitType, hitPend, hitEn;

  assign hitType = (regAddr == TYPE_OFFS);
  assign hitPend = (regAddr == PEND_OFFS);
  assign hitEn   = (regAddr == EN_OFFS);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      trigQ <= TRIG_LVL_LO;
      enQ   <= EN_RESET;
    end else if (regWr) begin
      if (hitType) trigQ <= trig_e'(regWdata[1:0]);
      if (hitEn)   enQ   <= regWdata[0];
    end
  end

  always_comb begin
    ctl.clearPend = regWr & hitPend & regWdata[0];
    ctl.trigType  = trigQ;
  end

  always_comb begin
    regRdata = '0;
    if (hitType)      regRdata = {{PAD_TYPE{1'b0}}, trigQ};
    else if (hitPend) regRdata = {{PAD_BIT{1'b0}}, latchQ & enQ};
    else if (hitEn)   regRdata = {{PAD_BIT{1'b0}}, enQ};
  end

  AST_TYPE_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && hitType) |=> (trigQ == $past(regWdata[1:0]))); // R2
  AST_PEND_MASKED: assert property (@(posedge clk) disable iff (!rstN)
    (hitPend && !enQ) |-> (regRdata == '0)); // R11
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (!hitType && !hitPend && !hitEn) |-> (regRdata == '0)); // R13
  AST_UNMAPPED_NOWRITE: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && !hitType && !hitEn) |=> ($stable(trigQ) && $stable(enQ))); // R13

endmodule

// File: rtl/nmi_trigger_latch.sv
module nmi_trigger_latch
  import nmi_latch_pkg::*;
#(
  parameter int                ADDR_W      = 8,
  parameter int                DATA_W      = 32,
  parameter int                SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] TYPE_OFFS   = 8'h0C,
  parameter logic [ADDR_W-1:0] PEND_OFFS   = 8'h10,
  parameter logic [ADDR_W-1:0] EN_OFFS     = 8'h40
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              nmiPin,
  input  logic              regWr,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  output logic              irqReq
);

  logic        pinSync;
  logic        latchQ;
  ctl_strobe_t ctl;

  nmi_pin_sync #(
    .STAGES    (SYNC_STAGES),
    .RESET_VAL (1'b1)
  ) u_sync (
    .clk      (clk),
    .rstN     (rstN),
    .pinAsync (nmiPin),
    .pinSync  (pinSync)
  );

  nmi_reg_ctrl #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .TYPE_OFFS (TYPE_OFFS),
    .PEND_OFFS (PEND_OFFS),
    .EN_OFFS   (EN_OFFS),
    .EN_RESET  (1'b1)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .regWr    (regWr),
    .regAddr  (regAddr),
    .regWdata (regWdata),
    .latchQ   (latchQ),
    .ctl      (ctl),
    .regRdata (regRdata)
  );

  nmi_trig_datapath u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .pinSync (pinSync),
    .ctl     (ctl),
    .latchQ  (latchQ)
  );

  assign irqReq = latchQ;

endmodule

// File: tb/nmi_trigger_latch_tb.sv
`timescale 1ns/1ps
module nmi_trigger_latch_tb;

  localparam logic [7:0] A_TYPE = 8'h0C;
  localparam logic [7:0] A_PEND = 8'h10;
  localparam logic [7:0] A_EN   = 8'h40;
  localparam logic [7:0] A_NONE = 8'h20;

  logic        clk = 1'b0;
  logic        rstN, nmiPin, regWr;
  logic [7:0]  regAddr;
  logic [31:0] regWdata, regRdata;
  logic        irqReq;
  int          checks = 0;
  int          errors = 0;
  bit          done = 0;

  always #2 clk = ~clk;

  nmi_trigger_latch u_dut (
    .clk(clk), .rstN(rstN), .nmiPin(nmiPin), .regWr(regWr),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata), .irqReq(irqReq)
  );

  // Cycle model built from the requirements
  logic       mS0, mS1, mPrev, mLatch, mEn;
  logic [1:0] mType;

  function automatic logic evtOf(logic [1:0] t, logic s, logic p);
    case (t)
      2'd0: return ~s;
      2'd1: return p & ~s;
      2'd2: return s;
      default: return ~p & s;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mS0 <= 1'b1; mS1 <= 1'b1; mPrev <= 1'b1; mLatch <= 1'b0;
      mType <= 2'd0; mEn <= 1'b1;
    end else begin
      mS0 <= nmiPin; mS1 <= mS0; mPrev <= mS1;
      if (regWr && regAddr == A_TYPE) mType <= regWdata[1:0];
      if (regWr && regAddr == A_EN)   mEn   <= regWdata[0];
      if (evtOf(mType, mS1, mPrev)) mLatch <= 1'b1;
      else if (regWr && regAddr == A_PEND && regWdata[0]) mLatch <= 1'b0;
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Called at a falling edge; the write lands on the next rising edge
  task automatic wrReg(logic [7:0] a, logic [31:0] d);
    regWr = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic rdReg(logic [7:0] a, output logic [31:0] d);
    regAddr = a;
    #0.5;
    d = regRdata;
  endtask

  task automatic waitN(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(4.0 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finishRun();
    end
  end

  initial begin
    logic [31:0] rd;
    void'($urandom(32'h5EED_1234));
    rstN = 1'b0; nmiPin = 1'b1; regWr = 1'b0; regAddr = A_NONE; regWdata = '0;
    waitN(4);
    rstN = 1'b1;
    waitN(1);

    // R1 reset state
    check("R1 irqReq", irqReq, 0);
    rdReg(A_TYPE, rd); check("R1 type", rd, 0);
    rdReg(A_EN, rd);   check("R1 enable", rd, 1);
    rdReg(A_PEND, rd); check("R1 pending", rd, 0);

    // R2 field position, upper bits read 0
    @(negedge clk);
    wrReg(A_TYPE, 32'hFFFF_FFF5);
    rdReg(A_TYPE, rd); check("R2 type low bits", rd, 1);
    @(negedge clk);
    wrReg(A_TYPE, 32'd3);
    rdReg(A_TYPE, rd); check("R2 rising", rd, 3);

    // R3 rising: falling ignored, rising sets; R12 latency
    @(negedge clk);
    nmiPin = 1'b0; waitN(4);
    check("R3 falling ignored", irqReq, 0);
    nmiPin = 1'b1; waitN(2);
    check("R12 not after two edges", irqReq, 0);
    waitN(1);
    check("R12 R3 set after three edges", irqReq, 1);
    rdReg(A_PEND, rd); check("R11 pending enabled", rd, 1);

    // R7 sticky
    @(negedge clk);
    nmiPin = 1'b0; waitN(4);
    check("R7 sticky", irqReq, 1);

    // R8 clear semantics
    wrReg(A_PEND, 32'hFFFF_FFFE);
    check("R8 bit0 zero no effect", irqReq, 1);
    wrReg(A_PEND, 32'd1);
    check("R8 clear", irqReq, 0);

    // R11 enable masks only the status
    wrReg(A_EN, 32'd0);
    nmiPin = 1'b1; waitN(3);
    check("R11 irqReq unmasked", irqReq, 1);
    rdReg(A_PEND, rd); check("R11 pending masked", rd, 0);
    @(negedge clk);
    wrReg(A_EN, 32'd1);
    rdReg(A_PEND, rd); check("R11 pending unmasked", rd, 1);
    @(negedge clk);
    wrReg(A_PEND, 32'd1);
    check("R8 clear again", irqReq, 0);

    // R10 set wins over clear in the same cycle
    nmiPin = 1'b0; waitN(3);
    nmiPin = 1'b1; waitN(2);
    wrReg(A_PEND, 32'd1);
    check("R10 set wins", irqReq, 1);
    wrReg(A_PEND, 32'd1);
    check("R8 clear after set", irqReq, 0);

    // R5 high level and R9 clear while active
    wrReg(A_TYPE, 32'd2);
    waitN(1);
    check("R5 high level sets", irqReq, 1);
    wrReg(A_PEND, 32'd1);
    check("R9 level active keeps", irqReq, 1);
    nmiPin = 1'b0; waitN(3);
    check("R7 level sticky", irqReq, 1);
    wrReg(A_PEND, 32'd1);
    check("R5 clear after release", irqReq, 0);

    // R4 falling
    wrReg(A_TYPE, 32'd1);
    nmiPin = 1'b1; waitN(4);
    check("R4 rising ignored", irqReq, 0);
    nmiPin = 1'b0; waitN(3);
    check("R4 falling sets", irqReq, 1);
    wrReg(A_PEND, 32'd1);
    check("R4 clear", irqReq, 0);

    // R6 low level
    wrReg(A_TYPE, 32'd0);
    waitN(1);
    check("R6 low level sets", irqReq, 1);
    nmiPin = 1'b1; waitN(3);
    wrReg(A_PEND, 32'd1);
    waitN(3);
    check("R6 clear after release", irqReq, 0);

    // R13 unmapped offsets
    wrReg(A_NONE, 32'hFFFF_FFFF);
    rdReg(A_NONE, rd); check("R13 unmapped reads 0", rd, 0);
    rdReg(A_TYPE, rd); check("R13 type untouched", rd, 0);
    rdReg(A_EN, rd);   check("R13 enable untouched", rd, 1);

    // Random phase against the cycle model
    @(negedge clk);
    for (int i = 0; i < 4000; i++) begin
      check("R3-model irqReq R7 R10", irqReq, mLatch);
      rdReg(A_PEND, rd);
      check("R11 model pending", rd, {31'd0, mLatch & mEn});
      if ($urandom_range(3) == 0) nmiPin = ~nmiPin;
      if ($urandom_range(4) == 0) begin
        case ($urandom_range(3))
          0: begin regAddr = A_TYPE; regWdata = $urandom; end
          1: begin regAddr = A_PEND; regWdata = $urandom; end
          2: begin regAddr = A_EN;   regWdata = $urandom; end
          default: begin regAddr = A_NONE; regWdata = $urandom; end
        endcase
        regWr = 1'b1;
      end else begin
        regWr = 1'b0;
      end
      @(negedge clk);
    end
    regWr = 1'b0;

    done = 1;
    finishRun();
  end

endmodule